// File: doc/BRIEF.md
# Page-Wrapping Serial EEPROM Responder

This block is an I2C target that stands in for a 16 Kbit serial EEPROM. Its 2048 bytes are split into eight banks of 256 bytes. The bank is carried in the control byte, and the byte that follows a write control byte supplies the offset inside that bank. The block samples SCL and SDA with the system clock and drives SDA through an open-drain pull-down output. It handles byte writes, page writes, random reads, current-address reads and sequential reads.

Data bytes received during a write go into a 16-byte page buffer. The buffer is written into storage only when a STOP arrives. A modelled write cycle then runs for a set number of clock cycles. While it runs, the device does not acknowledge its control byte, so a master can poll for completion. During a write only the low four address bits advance. A burst that runs past the end of a page therefore wraps to the start of the same page. During a read the whole 11-bit address advances.

Top module: `eep_page_responder`

## Requirements
- R1: The device acknowledges only control bytes whose upper four bits are 1010. After any other control byte it leaves SDA released for every following clock until the next START.
- R2: Control byte bits [3:1] select the bank, which gives storage address bits [10:8]. Bit 0 selects the direction, where 1 means read.
- R3: After a write control byte, the next byte sets address bits [7:0]. The device acknowledges the control byte, the address byte and every data byte by pulling SDA low during the ninth clock.
- R4: During a write, only address bits [3:0] advance after each data byte. A byte written past offset 15 of a page goes to offset 0 of the same page. When more than 16 bytes are sent, the later bytes overwrite the earlier ones.
- R5: Received data bytes reach storage only after the STOP that ends the transfer. A read inside the same transfer returns the old contents. Bytes of the page that were not written keep their old values.
- R6: A STOP that ends a write with at least one data byte starts a write cycle of WR_CYCLES clock cycles (WR_CYCLES must be at least 16). During the write cycle no control byte is acknowledged. A STOP after a write that carried no data byte starts no write cycle.
- R7: A random read works as follows. The master sends a write control byte and an address byte, then a repeated START and a read control byte. The device then returns the byte at that address, most significant bit first.
- R8: In a sequential read, each master ACK advances the full 11-bit address. The address rolls over from 0x7FF to 0x000.
- R9: After a master NACK on a read byte, the device stops driving. SDA stays released until the next START, even if the master keeps clocking.
- R10: During reset and after reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Every bank gets a full page of data whose values depend on the bank, so a read that landed in the wrong bank would return wrong bytes. Sixteen page writes then cover every start offset inside one page. Their lengths range from one byte to bursts well past 16 bytes, and each whole page is read back. This separates correct wrapping from linear increment and from lost or extra overwrites. A write is held open across a repeated START to show that data reaches storage only at STOP. Polling straight after a STOP, and again after an address-only transfer, shows when the write cycle does and does not start. A read across 0x7FF and extra clocks after a NACK cover the full-width increment and the release of SDA.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CACK,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sh_q, scl_sh_d;
  logic [SYNC_STAGES-1:0] sda_sh_q, sda_sh_d;
  logic                   scl_p_q, sda_p_q;

  always_comb begin
    scl_sh_d = {scl_sh_q[SYNC_STAGES-2:0], scl_i};
    sda_sh_d = {sda_sh_q[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_p_q  <= 1'b1;
      sda_p_q  <= 1'b1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
      scl_p_q  <= scl_s;
      sda_p_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh_q[SYNC_STAGES-1];
  assign sda_s     = sda_sh_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter  int ADDR_W     = 11,
  parameter  int PAGE_BYTES = 16,
  parameter  int WR_CYCLES  = 200,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic [7:0]        load_data,
  input  logic              page_set,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              commit_req,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);

  localparam int HOLD  = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [7:0]            buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q, valid_d;
  logic [PAGE_W-1:0]     page_q, page_d;
  logic                  busy_q, busy_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [OFS_W-1:0]      slot;
  logic                  in_page;

  assign slot    = cnt_q[OFS_W-1:0];
  assign in_page = (cnt_q < CNT_W'(PAGE_BYTES));

  // one slot register per page byte, each with its own load enable
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load_en && (load_ofs == OFS_W'(g))) begin
        buf_q[g] <= load_data;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    page_d  = page_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    if (busy_q) begin
      if (in_page) begin
        valid_d[slot] = 1'b0;
      end
      if (cnt_q == CNT_W'(HOLD - 1)) begin
        busy_d = 1'b0;
      end
      cnt_d = cnt_q + 1'b1;
    end else begin
      if (page_set) begin
        page_d = page_in;
      end
      if (load_en) begin
        valid_d[load_ofs] = 1'b1;
      end
      if (commit_req && (|valid_q)) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      page_q  <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      page_q  <= page_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy      = busy_q;
  assign mem_we    = busy_q & in_page & valid_q[slot];
  assign mem_waddr = {page_q, slot};
  assign mem_wdata = buf_q[slot];

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !busy_q); // R6

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(HOLD))); // R6

  AST_COMMIT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !busy_q) |-> (valid_q == '0)); // R5

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter  int ADDR_W = 11,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/eep_page_responder.sv
module eep_page_responder
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int WR_CYCLES   = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int BANK_W = ADDR_W - 8;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sh_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q <= 2'b00;
    end else begin
      rst_sh_q <= {rst_sh_q[0], 1'b1};
    end
  end
  assign arst_n = rst_sh_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (arst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tgt_state_e        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              rd_q, rd_d;
  logic              pull_q, pull_d;
  logic              mack_q, mack_d;

  logic              load_en, page_set, commit_req, busy;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata, rdata;
  logic [PAGE_W-1:0] page_in;

  assign page_in = {ptr_q[ADDR_W-1:8], sh_q[7:OFS_W]};

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    ptr_d      = ptr_q;
    rd_d       = rd_q;
    pull_d     = pull_q;
    mack_d     = mack_q;
    load_en    = 1'b0;
    page_set   = 1'b0;
    commit_req = 1'b0;
    if (stop_det) begin
      state_d    = ST_IDLE;
      pull_d     = 1'b0;
      commit_req = 1'b1;
    end else if (start_det) begin
      state_d = ST_CTRL;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && (cnt_q != 4'd8)) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && (cnt_q == 4'd8)) begin
            case (state_q)
              ST_CTRL: begin
                if ((sh_q[7:4] == DEV_TYPE) && !busy) begin
                  pull_d               = 1'b1;
                  rd_d                 = sh_q[0];
                  ptr_d[ADDR_W-1:8]    = sh_q[BANK_W:1];
                  state_d              = ST_CACK;
                end else begin
                  state_d = ST_WAIT;
                end
              end
              ST_ADDR: begin
                ptr_d[7:0] = sh_q;
                page_set   = 1'b1;
                pull_d     = 1'b1;
                state_d    = ST_AACK;
              end
              default: begin
                load_en             = 1'b1;
                ptr_d[OFS_W-1:0]    = ptr_q[OFS_W-1:0] + 1'b1;
                pull_d              = 1'b1;
                state_d             = ST_WACK;
              end
            endcase
          end
        end
        ST_CACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              sh_d    = rdata;
              pull_d  = ~rdata[7];
              cnt_d   = 4'd1;
              state_d = ST_RDATA;
            end else begin
              pull_d  = 1'b0;
              cnt_d   = '0;
              state_d = ST_ADDR;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              pull_d  = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RACK;
            end else begin
              pull_d = ~sh_q[6];
              sh_d   = {sh_q[6:0], 1'b0};
              cnt_d  = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = rdata;
              pull_d  = ~rdata[7];
              cnt_d   = 4'd1;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      pull_q  <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rd_q    <= rd_d;
      pull_q  <= pull_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_pull_o = pull_q;

  eep_page_buf #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) u_pbuf (
    .clk        (clk),
    .rst_n      (arst_n),
    .load_en    (load_en),
    .load_ofs   (ptr_q[OFS_W-1:0]),
    .load_data  (sh_q),
    .page_set   (page_set),
    .page_in    (page_in),
    .commit_req (commit_req),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata)
  );

  eep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr_q),
    .rdata (rdata)
  );

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    (pull_q != $past(pull_q)) |-> !scl_s); // R3

  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!arst_n)
    ((state_q == ST_WAIT) || (state_q == ST_IDLE)) |-> !pull_q); // R9

  AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_CACK) |-> !busy); // R6

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    (($past(state_q) == ST_WDATA) && (state_q == ST_WACK))
      |-> (ptr_q[ADDR_W-1:OFS_W] == $past(ptr_q[ADDR_W-1:OFS_W]))); // R4

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    (($past(state_q) == ST_RDATA) && (state_q == ST_RACK))
      |-> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1))); // R8

endmodule

// File: tb/tb_eep_page_responder.sv
module tb_eep_page_responder;

  localparam int Q   = 4;
  localparam int WRC = 400;
  localparam int AW  = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic sda_pull;
  logic sda_line;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  eep_page_responder #(.WR_CYCLES(WRC)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull)
  );

  logic [7:0] model [1 << AW];
  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [7:0] dat(int i, int pass);
    return 8'((i * 13) + (pass * 31) + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic ack_m, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = ~ack_m; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic model_apply(input logic [10:0] a, input int len, input int pass);
    for (int i = 0; i < len; i++) begin
      model[{a[10:4], 4'(a[3:0] + i)}] = dat(i, pass);
    end
  endtask

  task automatic write_tx(input logic [10:0] a, input int len, input int pass,
                          input bit do_stop, input string tag);
    logic ack;
    i2c_start();
    send_byte({4'hA, a[10:8], 1'b0}, ack);
    chk(ack, "R3", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R3", ack, 1);
    for (int i = 0; i < len; i++) begin
      send_byte(dat(i, pass), ack);
      chk(ack, tag, ack, 1);
    end
    if (do_stop) begin
      i2c_stop();
      model_apply(a, len, pass);
    end
  endtask

  task automatic wait_ready(output bit got);
    logic ack;
    got = 1'b0;
    for (int p = 0; p < 20; p++) begin
      i2c_start();
      send_byte(8'hA0, ack);
      i2c_stop();
      if (ack) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic read_check(input logic [10:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte({4'hA, a[10:8], 1'b0}, ack);
    chk(ack, "R3", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R3", ack, 1);
    i2c_start();
    send_byte({4'hA, a[10:8], 1'b1}, ack);
    chk(ack, "R7", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == model[11'(a + i)], tag, b, model[11'(a + i)]);
    end
    i2c_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    bit got;
    m_scl = 1'b1;
    m_sda = 1'b1;
    rst_n = 1'b0;
    tick(5);
    chk(sda_pull == 1'b0, "R10", sda_pull, 0);
    rst_n = 1'b1;
    tick(10);
    chk(sda_pull == 1'b0, "R10", sda_pull, 0);

    // R1: every foreign device type is refused, and the next byte too
    for (int n = 0; n < 16; n++) begin
      if (n != 10) begin
        i2c_start();
        send_byte({4'(n), 4'b0000}, ack);
        chk(!ack, "R1", ack, 0);
        send_byte(8'hA0, ack);
        chk(!ack, "R1", ack, 0);
        i2c_stop();
      end
    end

    // R2: one page per bank, data depends on bank
    for (int bk = 0; bk < 8; bk++) begin
      write_tx({3'(bk), 8'h00}, 16, bk, 1'b1, "R3");
      wait_ready(got);
      chk(got, "R6", got, 1);
    end
    write_tx(11'h7F0, 16, 9, 1'b1, "R3");
    wait_ready(got);
    chk(got, "R6", got, 1);
    for (int bk = 0; bk < 8; bk++) begin
      read_check({3'(bk), 8'h00}, 16, "R2");
    end
    read_check(11'h50A, 1, "R7");
    read_check(11'h10F, 1, "R7");

    // R4: every start offset, lengths 1..19, whole page read back
    for (int s = 0; s < 16; s++) begin
      write_tx({3'd3, 4'h4, 4'(s)}, ((s * 5) % 19) + 1, s + 100, 1'b1, "R4");
      wait_ready(got);
      chk(got, "R6", got, 1);
      read_check(11'h340, 16, "R4");
    end

    // R5: data held until STOP
    write_tx(11'h200, 16, 40, 1'b0, "R5");
    i2c_start();
    send_byte({4'hA, 3'd2, 1'b1}, ack);
    chk(ack, "R5", ack, 1);
    recv_byte(1'b0, b);
    chk(b == model[11'h200], "R5", b, model[11'h200]);
    i2c_stop();
    model_apply(11'h200, 16, 40);
    wait_ready(got);
    chk(got, "R5", got, 1);
    read_check(11'h200, 16, "R5");

    // R6: busy after a data write, not after an address-only write
    write_tx(11'h600, 1, 77, 1'b1, "R6");
    i2c_start();
    send_byte(8'hA0, ack);
    i2c_stop();
    chk(!ack, "R6", ack, 0);
    wait_ready(got);
    chk(got, "R6", got, 1);
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'h00, ack);
    i2c_stop();
    i2c_start();
    send_byte(8'hA0, ack);
    i2c_stop();
    chk(ack, "R6", ack, 1);
    read_check(11'h600, 1, "R6");

    // R8: sequential read across the top of the array
    read_check(11'h7FE, 4, "R8");

    // R9: released after NACK while the master keeps clocking
    i2c_start();
    send_byte({4'hA, 3'd1, 1'b0}, ack);
    send_byte(8'h00, ack);
    i2c_start();
    send_byte({4'hA, 3'd1, 1'b1}, ack);
    recv_byte(1'b0, b);
    chk(b == model[11'h100], "R9", b, model[11'h100]);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R9", b, 8'hFF);
    recv_byte(1'b1, b);
    chk(b == 8'hFF, "R9", b, 8'hFF);
    i2c_stop();
    read_check(11'h100, 2, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule